// File: doc/BRIEF.md
# Instruction Block Cache-Fill Repacker

This block sits on the refill path of a primary instruction cache. Secondary memory delivers an instruction block of eight instructions in 40 bytes over a 64-bit bus. The block's eight 8-bit extension bytes arrive first, in one header beat. Four beats follow, each carrying two 32-bit base instructions. The repacker keeps the extension bytes in a one-direction byte shift register. On each instruction beat it shifts out two bytes and joins each one to its instruction, which yields two 40-bit cache words per beat.

A compatibility mode accepts plain 32-bit code. In this mode there is no header beat. Every beat carries two instructions, and each gets an all-zero extension byte. The output presents one registered instruction pair per accepted instruction beat. The pair carries the instruction number of its first (even, first-of-packet) slot and a done pulse on the last pair of the block. Cache tags and array writes belong to the consumer.

Top module: `ifill_repack`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` and `out_done` are low. A beat without `in_start` that arrives after reset produces no output.
- R2: In normal mode (`compat_mode`=0), a beat with `in_valid` and `in_start` both high is a header beat. It stores the eight extension bytes and produces no output pair.
- R3: Each instruction beat accepted at a rising edge raises `out_valid` for exactly one cycle after that edge. `out_instr0[31:0]` is beat bits 63..32, the lower-addressed word. `out_instr1[31:0]` is beat bits 31..0.
- R4: Extension byte j (0..7) is taken from header bits [63-8j -: 8], so byte 0 is the most significant byte. The pair with instruction number n carries byte n in `out_instr0[39:32]` and byte n+1 in `out_instr1[39:32]`.
- R5: `out_num` gives the instruction number of `out_instr0` within its block. It reads 0, 2, 4 and 6 for the first to fourth pairs, and `out_instr1` is instruction `out_num`+1.
- R6: `out_done` is high together with `out_valid` for the fourth pair, with `out_num`=6, and at no other time. After that pair, beats without `in_start` are ignored.
- R7: A beat with `in_start` during an unfinished block abandons that block. In normal mode the beat becomes the new header, and the next pair is numbered 0 and uses the new extension bytes.
- R8: In compatibility mode, the `in_start` beat is itself the first instruction beat (number 0). Every output instruction in this mode has bits 39..32 equal to zero.
- R9: A cycle with `in_valid` low produces no output and leaves the position in the block unchanged.
- R10: While no block is open, a beat with `in_valid` high and `in_start` low is ignored and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| compat_mode | input | 1 | 1: plain 32-bit code with zero extension bytes |
| in_valid | input | 1 | Fill beat present on `in_data` |
| in_start | input | 1 | Beat is the first beat of a block |
| in_data | input | 64 | Fill beat; lowest address in bits 63..56 |
| out_valid | output | 1 | Output pair valid this cycle |
| out_num | output | 3 | Instruction number of `out_instr0` |
| out_instr0 | output | 40 | Even instruction: {extension, base} |
| out_instr1 | output | 40 | Odd instruction: {extension, base} |
| out_done | output | 1 | Last pair of the block |

## Verification
The properties assume that `compat_mode` does not change between an instruction beat and the next cycle, when its pair is presented. They also assume that a block is begun only by a beat carrying `in_start`. The bench changes the mode only on a start beat, and it holds every input steady from one falling edge to the next. This keeps the mode-dependent zero-extension check and the data pass-through check within those assumptions. Gaps, stray beats while idle and restarts in mid-block are placed on purpose, so that the properties on silent cycles are exercised.

// File: rtl/ifill_repack_pkg.sv
package ifill_repack_pkg;

    localparam int BASE_W    = 32;
    localparam int EXT_W     = 8;
    localparam int INSTR_W   = BASE_W + EXT_W;
    localparam int BUS_W     = 64;
    localparam int PER_BEAT  = BUS_W / BASE_W;
    localparam int BLK_INSTR = BUS_W / EXT_W;
    localparam int PAIRS     = BLK_INSTR / PER_BEAT;
    localparam int PAIR_W    = $clog2(PAIRS);
    localparam int NUM_W     = $clog2(BLK_INSTR);
    localparam int SHIFT_W   = PER_BEAT * EXT_W;

    typedef struct packed {
        logic [EXT_W-1:0]  ext;
        logic [BASE_W-1:0] base;
    } instr_t;

    typedef enum logic [1:0] {
        BEAT_NONE,
        BEAT_HDR,
        BEAT_DATA
    } beat_kind_t;

    function automatic instr_t join_instr(input logic [EXT_W-1:0] e,
                                          input logic [BASE_W-1:0] b);
        instr_t r;
        r.ext  = e;
        r.base = b;
        return r;
    endfunction

    function automatic logic [NUM_W-1:0] pair_to_num(input logic [PAIR_W-1:0] p);
        return NUM_W'(p) * NUM_W'(PER_BEAT);
    endfunction

endpackage

// File: rtl/ifill_fill_seq.sv
module ifill_fill_seq
    import ifill_repack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              compat_mode,
    input  logic              in_valid,
    input  logic              in_start,
    output beat_kind_t        kind,
    output logic [PAIR_W-1:0] pair_idx,
    output logic              last_pair
);

    logic              open_q;
    logic [PAIR_W-1:0] cnt_q;

    always_comb begin
        kind     = BEAT_NONE;
        pair_idx = '0;
        if (in_valid) begin
            if (in_start) begin
                kind = compat_mode ? BEAT_DATA : BEAT_HDR;
            end else if (open_q) begin
                kind     = BEAT_DATA;
                pair_idx = cnt_q;
            end
        end
        last_pair = (kind == BEAT_DATA) && (pair_idx == PAIR_W'(PAIRS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            case (kind)
                BEAT_HDR: begin
                    open_q <= 1'b1;
                    cnt_q  <= '0;
                end
                BEAT_DATA: begin
                    open_q <= !last_pair;
                    cnt_q  <= pair_idx + PAIR_W'(1);
                end
                default: begin
                    open_q <= open_q;
                    cnt_q  <= cnt_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/ifill_ext_shifter.sv
module ifill_ext_shifter
    import ifill_repack_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  beat_kind_t            kind,
    input  logic [BUS_W-1:0]      hdr_data,
    output logic [EXT_W-1:0]      ext_head [PER_BEAT]
);

    logic [BUS_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (kind == BEAT_HDR) begin
            sr_q <= hdr_data;
        end else if (kind == BEAT_DATA) begin
            sr_q <= {sr_q[BUS_W-SHIFT_W-1:0], {SHIFT_W{1'b0}}};
        end
    end

    for (genvar k = 0; k < PER_BEAT; k++) begin : g_head
        assign ext_head[k] = sr_q[BUS_W-1-k*EXT_W -: EXT_W];
    end

endmodule

// File: rtl/ifill_pair_emit.sv
module ifill_pair_emit
    import ifill_repack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              compat_mode,
    input  beat_kind_t        kind,
    input  logic [PAIR_W-1:0] pair_idx,
    input  logic              last_pair,
    input  logic [BUS_W-1:0]  beat_data,
    input  logic [EXT_W-1:0]  ext_head [PER_BEAT],
    output logic              out_valid,
    output logic [NUM_W-1:0]  out_num,
    output instr_t            out_lane [PER_BEAT],
    output logic              out_done
);

    instr_t lane_nxt [PER_BEAT];

    for (genvar k = 0; k < PER_BEAT; k++) begin : g_lane
        assign lane_nxt[k] = join_instr(compat_mode ? '0 : ext_head[k],
                                        beat_data[BUS_W-1-k*BASE_W -: BASE_W]);

        always_ff @(posedge clk) begin
            if (rst) begin
                out_lane[k] <= '0;
            end else if (kind == BEAT_DATA) begin
                out_lane[k] <= lane_nxt[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_done  <= 1'b0;
            out_num   <= '0;
        end else begin
            out_valid <= (kind == BEAT_DATA);
            out_done  <= last_pair;
            if (kind == BEAT_DATA) begin
                out_num <= pair_to_num(pair_idx);
            end
        end
    end

endmodule

// File: rtl/ifill_repack.sv
module ifill_repack
    import ifill_repack_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 compat_mode,
    input  logic                 in_valid,
    input  logic                 in_start,
    input  logic [BUS_W-1:0]     in_data,
    output logic                 out_valid,
    output logic [NUM_W-1:0]     out_num,
    output logic [INSTR_W-1:0]   out_instr0,
    output logic [INSTR_W-1:0]   out_instr1,
    output logic                 out_done
);

    beat_kind_t        kind;
    logic [PAIR_W-1:0] pair_idx;
    logic              last_pair;
    logic [EXT_W-1:0]  ext_head [PER_BEAT];
    instr_t            lanes    [PER_BEAT];

    ifill_fill_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .compat_mode (compat_mode),
        .in_valid    (in_valid),
        .in_start    (in_start),
        .kind        (kind),
        .pair_idx    (pair_idx),
        .last_pair   (last_pair)
    );

    ifill_ext_shifter u_ext (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .hdr_data (in_data),
        .ext_head (ext_head)
    );

    ifill_pair_emit u_emit (
        .clk         (clk),
        .rst         (rst),
        .compat_mode (compat_mode),
        .kind        (kind),
        .pair_idx    (pair_idx),
        .last_pair   (last_pair),
        .beat_data   (in_data),
        .ext_head    (ext_head),
        .out_valid   (out_valid),
        .out_num     (out_num),
        .out_lane    (lanes),
        .out_done    (out_done)
    );

    assign out_instr0 = lanes[0];
    assign out_instr1 = lanes[1];

endmodule

// File: rtl/ifill_repack_chk.sv
module ifill_repack_chk (
    input logic        clk,
    input logic        rst,
    input logic        compat_mode,
    input logic        in_valid,
    input logic        in_start,
    input logic [63:0] in_data,
    input logic        out_valid,
    input logic [2:0]  out_num,
    input logic [39:0] out_instr0,
    input logic [39:0] out_instr1,
    input logic        out_done
);

    AST_HDR_SILENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_start && !compat_mode) |=> !out_valid); // R2

    AST_IDLE_GAP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R9

    AST_BASE_PASS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!out_valid ||
                      (out_instr0[31:0] == $past(in_data[63:32]) &&
                       out_instr1[31:0] == $past(in_data[31:0])))); // R3

    AST_DONE_LAST: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (out_valid && out_num == 3'd6)); // R6

    AST_EVEN_NUM: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_num[0]); // R5

    AST_COMPAT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_start && compat_mode) |=> (out_valid && out_num == 3'd0)); // R8

    AST_COMPAT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && compat_mode) |=> (!out_valid ||
            (out_instr0[39:32] == 8'd0 && out_instr1[39:32] == 8'd0))); // R8

endmodule

bind ifill_repack ifill_repack_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .compat_mode (compat_mode),
    .in_valid    (in_valid),
    .in_start    (in_start),
    .in_data     (in_data),
    .out_valid   (out_valid),
    .out_num     (out_num),
    .out_instr0  (out_instr0),
    .out_instr1  (out_instr1),
    .out_done    (out_done)
);

// File: tb/ifill_repack_bench.sv
module ifill_repack_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        compat_mode;
    logic        in_valid;
    logic        in_start;
    logic [63:0] in_data;
    logic        out_valid;
    logic [2:0]  out_num;
    logic [39:0] out_instr0;
    logic [39:0] out_instr1;
    logic        out_done;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    ifill_repack u_ifill_repack (
        .clk         (clk),
        .rst         (rst),
        .compat_mode (compat_mode),
        .in_valid    (in_valid),
        .in_start    (in_start),
        .in_data     (in_data),
        .out_valid   (out_valid),
        .out_num     (out_num),
        .out_instr0  (out_instr0),
        .out_instr1  (out_instr1),
        .out_done    (out_done)
    );

    typedef struct packed {
        logic        v;
        logic        s;
        logic        c;
        logic [63:0] d;
        logic        ev;
        logic [2:0]  en;
        logic        ed;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b0, 64'h1122334455667788, 1'b0, 3'd0, 1'b0}, // R2 header
        '{1'b1, 1'b0, 1'b0, 64'hC0DE0000C0DE0001, 1'b1, 3'd0, 1'b0}, // R3 R4
        '{1'b0, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 1'b0, 3'd0, 1'b0}, // R9 gap
        '{1'b1, 1'b0, 1'b0, 64'hC0DE0002C0DE0003, 1'b1, 3'd2, 1'b0}, // R5
        '{1'b1, 1'b0, 1'b0, 64'hC0DE0004C0DE0005, 1'b1, 3'd4, 1'b0}, // R5
        '{1'b1, 1'b0, 1'b0, 64'hC0DE0006C0DE0007, 1'b1, 3'd6, 1'b1}, // R6
        '{1'b1, 1'b0, 1'b0, 64'hDEADBEEF01234567, 1'b0, 3'd0, 1'b0}, // R6 R10
        '{1'b1, 1'b1, 1'b0, 64'hA1B2C3D4E5F60718, 1'b0, 3'd0, 1'b0}, // R2
        '{1'b1, 1'b0, 1'b0, 64'h1000000110000002, 1'b1, 3'd0, 1'b0}, // R4
        '{1'b1, 1'b1, 1'b0, 64'h0102030405060708, 1'b0, 3'd0, 1'b0}, // R7 restart
        '{1'b1, 1'b0, 1'b0, 64'h2000000320000004, 1'b1, 3'd0, 1'b0}, // R7
        '{1'b1, 1'b1, 1'b1, 64'h3000000530000006, 1'b1, 3'd0, 1'b0}, // R8 R7
        '{1'b1, 1'b0, 1'b1, 64'h3000000730000008, 1'b1, 3'd2, 1'b0}, // R8
        '{1'b1, 1'b0, 1'b1, 64'h3000000930000010, 1'b1, 3'd4, 1'b0}, // R8
        '{1'b1, 1'b0, 1'b1, 64'h3000001130000012, 1'b1, 3'd6, 1'b1}  // R8 R6
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [63:0] hdr;
        logic [7:0]  e0, e1;
        hdr         = '0;
        rst         = 1'b1;
        compat_mode = 1'b0;
        in_valid    = 1'b0;
        in_start    = 1'b0;
        in_data     = '0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
        check("R1 done in reset", {63'd0, out_done}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", {63'd0, out_valid}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            in_valid    = VECS[i].v;
            in_start    = VECS[i].s;
            compat_mode = VECS[i].c;
            in_data     = VECS[i].d;
            if (VECS[i].v && VECS[i].s && !VECS[i].c) hdr = VECS[i].d;
            @(negedge clk);
            check("R2/R3/R9/R10 valid", {63'd0, out_valid}, {63'd0, VECS[i].ev});
            check("R6 done", {63'd0, out_done}, {63'd0, VECS[i].ed});
            if (VECS[i].ev) begin
                e0 = VECS[i].c ? 8'd0 : hdr[63 - 8*int'(VECS[i].en) -: 8];
                e1 = VECS[i].c ? 8'd0 : hdr[55 - 8*int'(VECS[i].en) -: 8];
                check("R5 num", {61'd0, out_num}, {61'd0, VECS[i].en});
                check("R3/R4/R8 lane0", {24'd0, out_instr0}, {24'd0, e0, VECS[i].d[63:32]});
                check("R3/R4/R8 lane1", {24'd0, out_instr1}, {24'd0, e1, VECS[i].d[31:0]});
            end
        end

        // R1: reset in mid-block closes it
        in_valid = 1'b1; in_start = 1'b1; compat_mode = 1'b0;
        in_data  = 64'h5566778899AABBCC;
        @(negedge clk);
        in_start = 1'b0; in_data = 64'h4000000140000002;
        @(negedge clk);
        check("R4 lane0 ext", {56'd0, out_instr0[39:32]}, 64'h55);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1 valid during reset", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;
        in_valid = 1'b1; in_start = 1'b0; in_data = 64'h4000000340000004;
        @(negedge clk);
        check("R1 R10 beat after reset ignored", {63'd0, out_valid}, 64'd0);

        // R9: gap inside block keeps position
        in_start = 1'b1; in_data = 64'h0011223344556677;
        @(negedge clk);
        in_start = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 gap silent", {63'd0, out_valid}, 64'd0);
        in_valid = 1'b1; in_data = 64'h5000000150000002;
        @(negedge clk);
        check("R9 num after gap", {61'd0, out_num}, 64'd0);
        check("R4 ext after gap", {48'd0, out_instr0[39:32], out_instr1[39:32]}, 64'h0011);
        in_valid = 1'b0;
        @(negedge clk);
        check("R3 valid one cycle", {63'd0, out_valid}, 64'd0);
        finish_run();
    end

endmodule